// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block sits on a CPU's register bus and lets software move bytes into and out of a small on-chip nonvolatile data array. Software loads an address register and a data register through direct offsets. It then drives each transfer through a control register that is reachable only in bank 1. A transfer takes several cycles, and software polls its start bit until the hardware clears it.

A write runs only when software follows a strict two-step arming sequence. The first bus write sets the write enable. The bus write that immediately follows it sets the write start bit. Any other bus write in between cancels the arming.

A busy output tells the power-management logic that an operation is running. If a sleep request arrives while the block is busy, the operation is abandoned and an error flag is raised. The array itself is a behavioural model that powers up to all ones.

Top module: `eeprom_ctl`

## Requirements
- R1: After reset the control register reads 0x00, busy_o is low, the address and data registers read 0x00, and every array byte reads back as 0xFF.
- R2: The control register is at bus offset 0x40 and only while bank_sel_i is 1. Its fields are: bit 0 read start, bit 1 read enable, bit 2 write start, bit 3 write enable, bit 4 error. With bank_sel_i at 0, a write to offset 0x40 changes nothing and a read of offset 0x40 returns 0x00.
- R3: The address register (offset 0x02) and the data register (offset 0x03) can be accessed in either bank. Only the low 7 address bits are stored, so bit 7 reads back as 0.
- R4: A read operation starts only when bit 0 is written as 1 while the read enable is already 1. Otherwise bit 0 stays 0 and busy_o stays low.
- R5: A write operation starts only when bit 2 is written as 1 while write enable is 1, and only if the bus write just before it was a control write with bit 3 = 1 and bit 2 = 0. Otherwise nothing is written and busy_o stays low.
- R6: busy_o rises on the cycle after the starting control write. It then stays high for exactly RD_LAT cycles (default 4) on a read, or WR_LAT cycles (default 32) on a write.
- R7: When an operation finishes, its start bit clears. A finished read loads the addressed byte into the data register.
- R8: A finished write stores the data register at the address register location. Reading that location back returns the stored byte.
- R9: While busy_o is high, bus writes to the address and data registers are ignored. Control writes are also ignored, except that writing 0x00 clears both enable bits. An operation already in progress still finishes.
- R10: If sleep_req_i is high while busy_o is high, busy_o falls on the next cycle and the start bit clears. A write commits nothing, and a read leaves the data register unchanged. The error bit becomes 1.
- R11: The error bit clears on the next control write accepted while not busy.
- R12: Writing 0x00 to the control register clears both enables, so a start bit written on its own afterwards starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| bank_sel_i | input | 1 | Bank select; 1 exposes the control register |
| sleep_req_i | input | 1 | Low-power mode request |
| busy_o | output | 1 | Operation in progress |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data is combinational, so the bench reads each register back half a cycle after the write. busy_o is first seen high at the falling edge after the starting write. The bench counts the falling edges on which busy_o stays high, and a full read must give exactly 4 and a full write exactly 32. A sleep request held across one rising edge must leave busy_o low by the next falling edge, with the error bit already readable. The bench checks array contents against a model that it updates only after writes that completed.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int unsigned BUS_W = 8;

  localparam logic [BUS_W-1:0] OFS_ADDR = 8'h02;
  localparam logic [BUS_W-1:0] OFS_DATA = 8'h03;
  localparam logic [BUS_W-1:0] OFS_CTRL = 8'h40;

  localparam int unsigned B_RD   = 0;
  localparam int unsigned B_RDEN = 1;
  localparam int unsigned B_WR   = 2;
  localparam int unsigned B_WREN = 3;
  localparam int unsigned B_ERR  = 4;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;
endpackage

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq import eeprom_pkg::*; #(
  parameter int unsigned RD_LAT = 4,
  parameter int unsigned WR_LAT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_rd_i,
  input  logic start_wr_i,
  input  logic sleep_req_i,
  output logic busy_o,
  output op_e  op_o,
  output logic done_o,
  output logic abort_o
);
  localparam int unsigned MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

  logic             busy_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o  = busy_q && !sleep_req_i && (cnt_q == '0);
  assign abort_o = busy_q && sleep_req_i;
  assign busy_o  = busy_q;
  assign op_o    = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_READ;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_wr_i) begin
        busy_q <= 1'b1;
        op_q   <= OP_WRITE;
        cnt_q  <= CNT_W'(WR_LAT - 1);
      end else if (start_rd_i) begin
        busy_q <= 1'b1;
        op_q   <= OP_READ;
        cnt_q  <= CNT_W'(RD_LAT - 1);
      end
    end else if (abort_o || done_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // busy only ends through completion or abort
  assert_busy_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(done_o || abort_o));
  assert_busy_enter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && (start_rd_i || start_wr_i) |=> busy_q);
endmodule

// File: rtl/eeprom_ctl.sv
module eeprom_ctl import eeprom_pkg::*; #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned RD_LAT = 4,
  parameter int unsigned WR_LAT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [BUS_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  input  logic             bank_sel_i,
  input  logic             sleep_req_i,
  output logic             busy_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q;
  logic rd_q, rden_q, wr_q, wren_q, err_q, arm_q;

  logic sel_addr, sel_data, sel_ctrl, wr_ctrl;
  logic start_rd, start_wr;
  logic op_busy, op_done, op_abort;
  op_e  op_kind;
  logic arr_we;
  logic [BUS_W-1:0] arr_rdata;

  assign sel_addr = (bus_addr_i == OFS_ADDR);
  assign sel_data = (bus_addr_i == OFS_DATA);
  assign sel_ctrl = bank_sel_i && (bus_addr_i == OFS_CTRL);
  assign wr_ctrl  = bus_we_i && sel_ctrl;

  assign start_rd = wr_ctrl && !op_busy && bus_wdata_i[B_RD] && rden_q;
  assign start_wr = wr_ctrl && !op_busy && bus_wdata_i[B_WR] && wren_q && arm_q;
  assign arr_we   = op_done && (op_kind == OP_WRITE);
  assign busy_o   = op_busy;

  eeprom_seq #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_rd_i (start_rd),
    .start_wr_i (start_wr),
    .sleep_req_i(sleep_req_i),
    .busy_o     (op_busy),
    .op_o       (op_kind),
    .done_o     (op_done),
    .abort_o    (op_abort)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (arr_we),
    .addr_i (addr_q),
    .wdata_i(data_q),
    .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0; rden_q <= 1'b0; wr_q <= 1'b0; wren_q <= 1'b0;
      err_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      // arming survives exactly one bus write
      if (bus_we_i)
        arm_q <= wr_ctrl && !op_busy && bus_wdata_i[B_WREN] && !bus_wdata_i[B_WR];
      if (wr_ctrl) begin
        if (!op_busy) begin
          rden_q <= bus_wdata_i[B_RDEN];
          wren_q <= bus_wdata_i[B_WREN];
          rd_q   <= start_rd;
          wr_q   <= start_wr;
          err_q  <= 1'b0;
        end else if (bus_wdata_i == '0) begin
          rden_q <= 1'b0;
          wren_q <= 1'b0;
        end
      end
      if (op_done || op_abort) begin
        rd_q <= 1'b0;
        wr_q <= 1'b0;
      end
      if (op_abort) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_we_i && sel_addr && !op_busy) addr_q <= bus_wdata_i[ADDR_W-1:0];
      if (bus_we_i && sel_data && !op_busy) data_q <= bus_wdata_i;
      else if (op_done && op_kind == OP_READ) data_q <= arr_rdata;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_addr)      bus_rdata_o[ADDR_W-1:0] = addr_q;
    else if (sel_data) bus_rdata_o = data_q;
    else if (sel_ctrl) begin
      bus_rdata_o[B_RD]   = rd_q;
      bus_rdata_o[B_RDEN] = rden_q;
      bus_rdata_o[B_WR]   = wr_q;
      bus_rdata_o[B_WREN] = wren_q;
      bus_rdata_o[B_ERR]  = err_q;
    end
  end

  assert_bank0_blocked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && !bank_sel_i && bus_addr_i == OFS_CTRL && !op_busy
    |=> $stable({rd_q, rden_q, wr_q, wren_q, err_q}));
  assert_rd_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !rden_q && !op_busy |=> !rd_q);
  assert_wr_needs_arm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !arm_q && !op_busy |=> !wr_q);
  assert_self_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(op_busy) |-> !rd_q && !wr_q);
  assert_busy_addr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_busy && bus_we_i && sel_addr |=> $stable(addr_q));
  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_busy && sleep_req_i |=> !op_busy && err_q);
  assert_no_commit_sleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_i |-> !arr_we);
endmodule

// File: tb/eeprom_ctl_test.sv
`timescale 1ns/1ps
module eeprom_ctl_test;
  localparam int RD_LAT = 4;
  localparam int WR_LAT = 32;
  localparam logic [7:0] A_ADDR = 8'h02, A_DATA = 8'h03, A_CTRL = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, bank = 1'b0, sleep = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic busy;
  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] mdl [128];

  always #2.5 clk = ~clk;

  eeprom_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bank_sel_i(bank),
    .sleep_req_i(sleep), .busy_o(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  function automatic logic [7:0] ctrl_val(bit r, bit re, bit w, bit we_, bit e);
    return {3'b0, e, we_, w, re, r};
  endfunction

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d, output int n);
    wr(A_ADDR, a); wr(A_DATA, d);
    bank = 1'b1;
    wr(A_CTRL, 8'h08); wr(A_CTRL, 8'h0C);
    busy_len(n);
    wr(A_CTRL, 8'h00);
    bank = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [7:0] v, output int n);
    wr(A_ADDR, a);
    bank = 1'b1;
    wr(A_CTRL, 8'h02); wr(A_CTRL, 8'h03);
    busy_len(n);
    wr(A_CTRL, 8'h00);
    bank = 1'b0;
    rd(A_DATA, v);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd20251));
    for (int i = 0; i < 128; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bank = 1'b1; rd(A_CTRL, v); chk("R1 ctrl", v, 0); bank = 1'b0;
    chk("R1 busy", busy, 0);
    rd(A_ADDR, v); chk("R1 addr", v, 0);
    rd(A_DATA, v); chk("R1 data", v, 0);
    do_read(8'h00, v, n); chk("R1 array", v, 8'hFF);
    chk("R6 read busy length", n, RD_LAT);

    // R3 direct access, bit 7 dropped
    wr(A_ADDR, 8'h85); rd(A_ADDR, v); chk("R3 addr bit7", v, 8'h05);
    bank = 1'b1; wr(A_DATA, 8'h3C); rd(A_DATA, v); chk("R3 data bank1", v, 8'h3C); bank = 1'b0;

    // R2 bank 0 cannot reach control
    wr(A_CTRL, 8'h0A); rd(A_CTRL, v); chk("R2 bank0 read", v, 0);
    bank = 1'b1; rd(A_CTRL, v); chk("R2 bank0 write ignored", v, 0);
    // R2 field positions
    wr(A_CTRL, 8'h0A); rd(A_CTRL, v); chk("R2 enables", v, ctrl_val(0,1,0,1,0));
    wr(A_CTRL, 8'h00); bank = 1'b0;

    // R4 RD without RDEN
    bank = 1'b1; wr(A_CTRL, 8'h01);
    chk("R4 busy", busy, 0); rd(A_CTRL, v); chk("R4 rd bit", v, 0);
    // R4 RD and RDEN together still no start
    wr(A_CTRL, 8'h03); chk("R4 same write", busy, 0);
    rd(A_CTRL, v); chk("R4 same write ctrl", v, ctrl_val(0,1,0,0,0));
    wr(A_CTRL, 8'h00); bank = 1'b0;

    // R8 armed write then read back
    do_write(8'h11, 8'hA5, n); mdl[8'h11] = 8'hA5;
    chk("R6 write busy length", n, WR_LAT);
    do_read(8'h11, v, n); chk("R8 readback", v, 8'hA5);

    // R5 interrupted arming
    wr(A_ADDR, 8'h11); wr(A_DATA, 8'h22);
    bank = 1'b1; wr(A_CTRL, 8'h08); wr(A_DATA, 8'h22); wr(A_CTRL, 8'h0C);
    chk("R5 no start", busy, 0);
    rd(A_CTRL, v); chk("R5 wr bit", v, ctrl_val(0,0,0,1,0));
    wr(A_CTRL, 8'h00); bank = 1'b0;
    do_read(8'h11, v, n); chk("R5 array kept", v, 8'hA5);

    // R7 start bit visible while busy, cleared after
    wr(A_ADDR, 8'h11); bank = 1'b1; wr(A_CTRL, 8'h02); wr(A_CTRL, 8'h03);
    rd(A_CTRL, v); chk("R7 rd bit set", v, ctrl_val(1,1,0,0,0));
    busy_len(n); rd(A_CTRL, v); chk("R7 rd bit cleared", v, ctrl_val(0,1,0,0,0));
    wr(A_CTRL, 8'h00); bank = 1'b0;
    rd(A_DATA, v); chk("R7 data loaded", v, 8'hA5);

    // R9 writes during busy
    wr(A_ADDR, 8'h10); wr(A_DATA, 8'h5A);
    bank = 1'b1; wr(A_CTRL, 8'h08); wr(A_CTRL, 8'h0C);
    wr(A_ADDR, 8'h20); wr(A_DATA, 8'h99); wr(A_CTRL, 8'h00);
    rd(A_CTRL, v); chk("R9 ctrl clear", v, ctrl_val(0,0,1,0,0));
    chk("R9 still busy", busy, 1);
    busy_len(n); bank = 1'b0; mdl[8'h10] = 8'h5A;
    rd(A_ADDR, v); chk("R9 addr held", v, 8'h10);
    rd(A_DATA, v); chk("R9 data held", v, 8'h5A);
    do_read(8'h10, v, n); chk("R9 op finished", v, 8'h5A);

    // R12 cleared enables block a lone start
    bank = 1'b1; wr(A_CTRL, 8'h0A); wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h01);
    chk("R12 no read", busy, 0);
    wr(A_CTRL, 8'h04); chk("R12 no write", busy, 0);
    rd(A_CTRL, v); chk("R12 ctrl", v, 0);
    wr(A_CTRL, 8'h00); bank = 1'b0;

    // R10 sleep during write
    wr(A_ADDR, 8'h30); wr(A_DATA, 8'h77);
    bank = 1'b1; wr(A_CTRL, 8'h08); wr(A_CTRL, 8'h0C);
    repeat (3) @(negedge clk);
    sleep = 1'b1; @(negedge clk); sleep = 1'b0;
    chk("R10 busy dropped", busy, 0);
    rd(A_CTRL, v); chk("R10 err set", v, ctrl_val(0,0,0,1,1));
    // R11 error clears on control write
    wr(A_CTRL, 8'h00); rd(A_CTRL, v); chk("R11 err cleared", v, 0);
    bank = 1'b0;
    do_read(8'h30, v, n); chk("R10 write dropped", v, mdl[8'h30]);

    // R10 sleep during read keeps data register
    wr(A_DATA, 8'hAB); wr(A_ADDR, 8'h11);
    bank = 1'b1; wr(A_CTRL, 8'h02); wr(A_CTRL, 8'h03);
    sleep = 1'b1; @(negedge clk); sleep = 1'b0;
    chk("R10 read aborted", busy, 0);
    wr(A_CTRL, 8'h00); bank = 1'b0;
    rd(A_DATA, v); chk("R10 read data kept", v, 8'hAB);

    // R8 random write/read pairs against the model
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, d, b;
      a = 8'($urandom); d = 8'($urandom);
      do_write(a, d, n); mdl[a[6:0]] = d;
      chk("R6 write busy length", n, WR_LAT);
      b = (i % 2 == 0) ? a : 8'($urandom);
      do_read(b, v, n); chk("R8 random readback", v, mdl[b[6:0]]);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule